// File: doc/BRIEF.md
# Lockstep Upset Miscompare Monitor

This block detects single event upsets in on-chip resources by running two structurally identical datapaths side by side. A single pseudo-random source feeds both copies with the same stimulus every clock. Each copy exercises a multiplier, a block memory, a long single-bit flip-flop chain and a deep multi-bit shift chain. Each copy folds the outputs of these resources into one signature per cycle. A comparator counts every cycle in which the two signatures disagree, in a saturating counter.

The count leaves the block on one serial line. At a fixed interval a frame is launched: a sync byte, then the counter value. A host logs the frames. The serial line has no back-pressure: the host must always accept. Inside the block, bytes move from the framer to the transmitter over a valid/ready pair, and the framer holds a byte until the transmitter is ready. A test-only input corrupts one copy's signature, so a bench can confirm the counting path. A synchronous clear zeroes the count and restarts warm-up.

Top module: `seu_monitor`

## Requirements
- R1: While and after reset, `tx` idles high, and no frame starts until the first report interval of 2^REPORT_LOG2 cycles has elapsed.
- R2: A frame is the sync byte 0xA5, then COUNT_W/8 count bytes, most significant byte first. Each byte is 8N1: a low start bit, eight data bits least significant first, and a high stop bit, each lasting BAUD_DIV cycles.
- R3: Frames start exactly 2^REPORT_LOG2 cycles apart. The count is captured when the frame is launched, and a new frame is never launched while one is still being sent.
- R4: Both copies receive the same stimulus from a 31-bit LFSR (polynomial x^31+x^28+1, non-zero seed) whose state never becomes zero. With `fault_inj` held low, the reported count stays 0.
- R5: After warm-up, each clock cycle in which `fault_inj` is high adds exactly one to the count.
- R6: During the warm-up after reset, miscompares are not counted. Warm-up lasts WARMUP cycles, or longer if needed to cover the deepest storage plus pipeline.
- R7: The count saturates at all-ones and does not wrap.
- R8: `clear` zeroes the count and restarts warm-up, so miscompares just after `clear` are not counted.
- R9: `clear` asserted while a frame is being sent does not change that frame's bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous count clear and warm-up restart |
| fault_inj | input | 1 | Test-only: flips bit 0 of the second copy's signature this cycle |
| tx | output | 1 | Serial report line, 8N1, idles high |

## Verification
The hardest case to reach from the ports is a real divergence between the two copies, because identical logic fed the same stimulus never disagrees. The bench uses `fault_inj` to corrupt signatures for chosen numbers of cycles: isolated pulses, long bursts, and pulses placed inside the warm-up window after reset and after `clear`. It then decodes every serial frame to recover the count. Reaching saturation takes a burst longer than the counter's range, so the bench builds the design with a 16-bit count and short report interval. It also times a `clear` to land inside a frame that is being sent.

// File: rtl/seu_pkg.sv
package seu_pkg;
  localparam int unsigned LFSR_W = 31;
  localparam logic [7:0] SYNC_BYTE = 8'hA5;
  localparam int unsigned PIPE_SLACK = 4;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Warm-up length: requested count, stretched to cover the deepest storage.
  function automatic int unsigned warm_len(input int unsigned req, input int unsigned mem_depth,
                                           input int unsigned ff_len, input int unsigned sr_len);
    return max2(max2(req, mem_depth), max2(ff_len, sr_len)) + PIPE_SLACK;
  endfunction
endpackage

// File: rtl/seu_stim_gen.sv
module seu_stim_gen #(
  parameter int unsigned OP_W   = 18,
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned MEM_DW = 18,
  parameter int unsigned SR_W   = 4,
  parameter logic [30:0] SEED   = 31'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [OP_W-1:0]   op_a,
  output logic [OP_W-1:0]   op_b,
  output logic [MEM_AW-1:0] addr,
  output logic [MEM_DW-1:0] wdata,
  output logic              ff_in,
  output logic [SR_W-1:0]   srl_in
);
  import seu_pkg::*;
  localparam int unsigned POOL_W = 3 * LFSR_W;

  logic [LFSR_W-1:0] lfsr;
  logic [POOL_W-1:0] pool;
  logic              fb;

  assign fb = lfsr[30] ^ lfsr[27];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= SEED;
      addr <= '0;
    end else begin
      lfsr <= {lfsr[29:0], fb};
      addr <= addr + 1'b1;
    end
  end

  assign pool   = {lfsr, lfsr[14:0], lfsr[30:15], lfsr};
  assign op_a   = pool[OP_W-1:0];
  assign op_b   = pool[31 +: OP_W];
  assign wdata  = pool[62 +: MEM_DW];
  assign srl_in = pool[40 +: SR_W];
  assign ff_in  = lfsr[7] ^ lfsr[19];

  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lfsr) != '0 |-> lfsr != '0);
endmodule

// File: rtl/seu_datapath.sv
module seu_datapath #(
  parameter int unsigned OP_W   = 18,
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned MEM_DW = 18,
  parameter int unsigned FF_LEN = 512,
  parameter int unsigned SR_LEN = 256,
  parameter int unsigned SR_W   = 4,
  parameter int unsigned SIG_W  = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [MEM_AW-1:0] addr,
  input  logic [MEM_DW-1:0] wdata,
  input  logic              ff_in,
  input  logic [SR_W-1:0]   srl_in,
  output logic [SIG_W-1:0]  sig
);
  localparam int unsigned MEM_DEPTH = 1 << MEM_AW;

  logic [SIG_W-1:0]  prod_q;
  logic [MEM_DW-1:0] mem [MEM_DEPTH];
  logic [MEM_DW-1:0] rd_q;
  logic [FF_LEN-1:0] ffc;
  logic [SR_W-1:0]   srl [SR_LEN];

  // Multiplier and memory: read-before-write at the cycling address.
  always_ff @(posedge clk) begin
    prod_q    <= SIG_W'(op_a * op_b);
    rd_q      <= mem[addr];
    mem[addr] <= wdata;
  end

  // Single-bit flip-flop chain, reset to zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ffc <= '0;
    else        ffc <= {ffc[FF_LEN-2:0], ff_in};
  end

  // Multi-bit shift chain without reset, one stage per generate step.
  for (genvar s = 0; s < SR_LEN; s++) begin : g_srl
    if (s == 0) begin : g_head
      always_ff @(posedge clk) srl[0] <= srl_in;
    end else begin : g_body
      always_ff @(posedge clk) srl[s] <= srl[s-1];
    end
  end

  always_ff @(posedge clk) begin
    sig <= prod_q ^ SIG_W'(rd_q) ^ SIG_W'(ffc[FF_LEN-1]) ^ SIG_W'(srl[SR_LEN-1]);
  end
endmodule

// File: rtl/seu_tally.sv
module seu_tally #(
  parameter int unsigned SIG_W    = 36,
  parameter int unsigned COUNT_W  = 32,
  parameter int unsigned WARM_CYC = 1028
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [SIG_W-1:0]   sig_a,
  input  logic [SIG_W-1:0]   sig_b,
  output logic [COUNT_W-1:0] count
);
  localparam int unsigned WW = $clog2(WARM_CYC + 1);

  logic [WW-1:0] wcnt;
  logic          warm;
  logic          miss_q;

  assign warm = (wcnt == WW'(WARM_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt   <= '0;
      miss_q <= 1'b0;
      count  <= '0;
    end else if (clear) begin
      wcnt   <= '0;
      miss_q <= 1'b0;
      count  <= '0;
    end else begin
      if (!warm) wcnt <= wcnt + 1'b1;
      miss_q <= warm && (sig_a != sig_b);
      if (miss_q && count != '1) count <= count + 1'b1;
    end
  end

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && miss_q && count != '1) |=> count == $past(count) + COUNT_W'(1));
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && count == '1) |=> count == '1);
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && !miss_q));
endmodule

// File: rtl/seu_uart_tx.sv
module seu_uart_tx #(
  parameter int unsigned BAUD_DIV = 868
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       tx
);
  localparam int unsigned BW = (BAUD_DIV > 2) ? $clog2(BAUD_DIV) : 1;

  logic [9:0]    sh;
  logic          active;
  logic [BW-1:0] bcnt;
  logic [3:0]    nbit;
  logic          take;

  assign in_ready = !active;
  assign take     = in_valid && in_ready;
  assign tx       = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      active <= 1'b0;
      bcnt   <= '0;
      nbit   <= '0;
    end else if (take) begin
      sh     <= {1'b1, in_data, 1'b0};
      active <= 1'b1;
      bcnt   <= '0;
      nbit   <= '0;
    end else if (active) begin
      if (bcnt == BW'(BAUD_DIV - 1)) begin
        bcnt <= '0;
        sh   <= {1'b1, sh[9:1]};
        if (nbit == 4'd9) active <= 1'b0;
        else              nbit   <= nbit + 1'b1;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !tx);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !take) |=> tx);
endmodule

// File: rtl/seu_reporter.sv
module seu_reporter #(
  parameter int unsigned COUNT_W     = 32,
  parameter int unsigned REPORT_LOG2 = 20,
  parameter int unsigned BAUD_DIV    = 868
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COUNT_W-1:0] count,
  output logic               tx
);
  import seu_pkg::*;
  localparam int unsigned NB = COUNT_W / 8;
  localparam int unsigned IW = $clog2(NB + 1);

  logic [REPORT_LOG2-1:0] timer;
  logic                   tick;
  logic                   busy;
  logic [IW-1:0]          idx;
  logic [COUNT_W-1:0]     snap;
  logic [7:0]             cur;
  logic                   b_ready;

  assign tick = &timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      busy  <= 1'b0;
      idx   <= '0;
      snap  <= '0;
    end else begin
      timer <= timer + 1'b1;
      if (tick) begin
        busy <= 1'b1;
        idx  <= '0;
        snap <= count;
      end else if (busy && b_ready) begin
        if (idx == IW'(NB)) busy <= 1'b0;
        else                idx  <= idx + 1'b1;
      end
    end
  end

  // Byte select: sync first, then count bytes from the top down.
  always_comb begin
    cur = SYNC_BYTE;
    for (int k = 1; k <= NB; k++) begin
      if (idx == IW'(k)) cur = snap[(NB-k)*8 +: 8];
    end
  end

  seu_uart_tx #(.BAUD_DIV(BAUD_DIV)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (busy),
    .in_ready (b_ready),
    .in_data  (cur),
    .tx       (tx)
  );

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !busy);
  assert_snap_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy ? snap == $past(snap) : 1'b1));
endmodule

// File: rtl/seu_monitor.sv
module seu_monitor #(
  parameter int unsigned OP_W        = 18,
  parameter int unsigned MEM_AW      = 10,
  parameter int unsigned MEM_DW      = 18,
  parameter int unsigned FF_LEN      = 512,
  parameter int unsigned SR_LEN      = 256,
  parameter int unsigned SR_W        = 4,
  parameter int unsigned WARMUP      = 1024,
  parameter int unsigned COUNT_W     = 32,
  parameter int unsigned REPORT_LOG2 = 20,
  parameter int unsigned BAUD_DIV    = 868,
  parameter logic [30:0] SEED        = 31'h1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fault_inj,
  output logic tx
);
  import seu_pkg::*;
  localparam int unsigned SIG_W    = 2 * OP_W;
  localparam int unsigned WARM_CYC = warm_len(WARMUP, 1 << MEM_AW, FF_LEN, SR_LEN);
  localparam int unsigned NCOPY    = 2;

  logic [OP_W-1:0]   op_a, op_b;
  logic [MEM_AW-1:0] addr;
  logic [MEM_DW-1:0] wdata;
  logic              ff_in;
  logic [SR_W-1:0]   srl_in;
  logic [SIG_W-1:0]  sig [NCOPY];
  logic [SIG_W-1:0]  sig_b_hit;
  logic [COUNT_W-1:0] count;

  seu_stim_gen #(.OP_W(OP_W), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .SR_W(SR_W), .SEED(SEED)) u_stim (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .addr(addr),
    .wdata(wdata), .ff_in(ff_in), .srl_in(srl_in)
  );

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    seu_datapath #(
      .OP_W(OP_W), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .FF_LEN(FF_LEN),
      .SR_LEN(SR_LEN), .SR_W(SR_W), .SIG_W(SIG_W)
    ) u_dp (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .addr(addr),
      .wdata(wdata), .ff_in(ff_in), .srl_in(srl_in), .sig(sig[c])
    );
  end

  assign sig_b_hit = sig[1] ^ SIG_W'(fault_inj);

  seu_tally #(.SIG_W(SIG_W), .COUNT_W(COUNT_W), .WARM_CYC(WARM_CYC)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .sig_a(sig[0]), .sig_b(sig_b_hit), .count(count)
  );

  seu_reporter #(.COUNT_W(COUNT_W), .REPORT_LOG2(REPORT_LOG2), .BAUD_DIV(BAUD_DIV)) u_rep (
    .clk(clk), .rst_n(rst_n), .count(count), .tx(tx)
  );
endmodule

// File: tb/seu_monitor_bench.sv
module seu_monitor_bench;
  localparam int BD   = 4;
  localparam int RL2  = 10;
  localparam int CW   = 16;
  localparam int NB   = CW / 8;
  localparam int IVAL = 1 << RL2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic fault_inj = 1'b0;
  logic tx;

  int nchk = 0, nerr = 0;
  int cyc = 0;
  int frames_seen = 0;
  int last_val = 0;
  int last_bytes [NB];
  int starts [256];
  int frame_err = 0, sync_err = 0;
  bit done = 0;
  event frame_start;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seu_monitor #(
    .OP_W(18), .MEM_AW(4), .MEM_DW(18), .FF_LEN(8), .SR_LEN(4), .SR_W(4),
    .WARMUP(32), .COUNT_W(CW), .REPORT_LOG2(RL2), .BAUD_DIV(BD), .SEED(31'h5A5A1)
  ) u_seu_monitor (
    .clk(clk), .rst_n(rst_n), .clear(clear), .fault_inj(fault_inj), .tx(tx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Serial decoder: sync byte then NB count bytes per frame.
  initial begin
    int state = 0;
    int acc = 0;
    int st_cyc = 0;
    forever begin
      logic [7:0] b;
      @(negedge tx);
      repeat (BD / 2) @(negedge clk);
      st_cyc = cyc;
      if (tx !== 1'b0) frame_err++;
      for (int i = 0; i < 8; i++) begin
        repeat (BD) @(negedge clk);
        b[i] = tx;
      end
      repeat (BD) @(negedge clk);
      if (tx !== 1'b1) frame_err++;
      if (state == 0) begin
        if (b == 8'hA5) begin
          state = 1;
          acc = 0;
          if (frames_seen < 256) starts[frames_seen] = st_cyc;
          ->frame_start;
        end else sync_err++;
      end else begin
        last_bytes[state-1] = int'(b);
        acc = (acc << 8) | int'(b);
        if (state == NB) begin
          state = 0;
          last_val = acc;
          frames_seen++;
        end else state++;
      end
    end
  end

  task automatic next_frames(input int n, output int val);
    int target;
    target = frames_seen + n;
    wait (frames_seen >= target);
    val = last_val;
    @(negedge clk);
  endtask

  task automatic burst(input int n);
    @(negedge clk) fault_inj = 1'b1;
    repeat (n) @(negedge clk);
    fault_inj = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fault_inj = 1'b1;
      @(negedge clk) fault_inj = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", frames_seen, 0);
    finish_run();
  end

  initial begin
    int v;
    int exp = 0;
    int rel;
    repeat (3) @(negedge clk);
    check(tx === 1'b1, "R1 tx idle in reset", int'(tx), 1);
    rst_n = 1'b1;
    rel = cyc;
    @(negedge clk);
    check(tx === 1'b1, "R1 tx idle after reset", int'(tx), 1);
    // Injections inside the post-reset warm-up must not count (R6).
    burst(18);
    while (cyc < rel + 1000) @(negedge clk);
    check(frames_seen == 0 && tx === 1'b1, "R1 no early frame", frames_seen, 0);

    next_frames(1, v);
    check(v == 0, "R6 warm-up miscompares ignored", v, 0);
    next_frames(1, v);
    check(v == 0, "R4 copies agree without faults", v, 0);

    pulses(1); exp = 1;
    next_frames(1, v);
    check(v == exp, "R5 single inject", v, exp);
    pulses(5); exp += 5;
    next_frames(1, v);
    check(v == exp, "R5 isolated injects", v, exp);
    burst(287); exp += 287;
    next_frames(1, v);
    check(v == exp, "R5 burst inject", v, exp);
    check(last_bytes[0] == 8'h01 && last_bytes[1] == 8'h25, "R2 msb first",
          (last_bytes[0] << 8) | last_bytes[1], 16'h0125);
    for (int k = 1; k < 5; k++)
      check(starts[k] - starts[k-1] == IVAL, "R3 frame spacing", starts[k] - starts[k-1], IVAL);

    // Clear during a frame that is already on the line (R9), then zero (R8).
    @(frame_start);
    pulse_clear();
    next_frames(1, v);
    check(v == exp, "R9 frame undisturbed by clear", v, exp);
    next_frames(1, v);
    check(v == 0, "R8 clear zeroes count", v, 0);

    pulse_clear();
    burst(10);
    repeat (100) @(negedge clk);
    pulses(3); exp = 3;
    next_frames(1, v);
    check(v == exp, "R8 warm-up restarts after clear", v, exp);
    check(frame_err == 0, "R2 start/stop bits", frame_err, 0);
    check(sync_err == 0, "R2 sync byte", sync_err, 0);

    burst(65600);
    next_frames(2, v);
    check(v == 16'hFFFF, "R7 saturates", v, 16'hFFFF);
    pulses(5);
    next_frames(2, v);
    check(v == 16'hFFFF, "R7 stays saturated", v, 16'hFFFF);
    check(starts[frames_seen-1] - starts[frames_seen-2] == IVAL, "R3 late spacing",
          starts[frames_seen-1] - starts[frames_seen-2], IVAL);
    check(frame_err == 0 && sync_err == 0, "R2 framing over run", frame_err + sync_err, 0);
    finish_run();
  end
endmodule